// File: doc/BRIEF.md
# Serial Controller FIFO Pair with Receive Trigger Levels

This block holds the transmit and receive byte queues of a 16550-class serial controller, together with the logic behind its FIFO control register. The host side writes the control register and the transmit holding register, and it reads the receive buffer. The line side delivers received bytes on a valid/ready stream and takes bytes to send from a second valid/ready stream. The block reports the fill level of each queue and the data-ready, holding-empty, transmitter-empty and overrun status bits. It also raises the received-data-available interrupt request.

When the FIFOs are disabled, each queue behaves as a single holding byte. When they are enabled, each holds 16 bytes, and the receive interrupt waits until the receive queue reaches a programmable trigger level. A configuration input gates all control-register writes, so a controller built in the older single-byte mode cannot switch the queues on.

Back-pressure: on the receive stream, `rx_ready` is low while the receive queue is full. A byte offered anyway is dropped and latches the overrun bit. On the transmit stream, a byte leaves on every clock edge where `tx_valid` and `tx_ready` are both high. The host transmit write never stalls. A write into a full transmit queue replaces the oldest entry.

Top module: `serial_fifo_ctl`

## Requirements
- R1: After reset, both counts are 0, data-ready is 0, holding-empty and transmitter-empty are 1, overrun is 0, the stored control value is 0x00, the interrupt is low and `rx_ready` is 1.
- R2: With FIFOs enabled, each queue accepts up to 16 bytes, delivers them in arrival order, and its count output tracks the number held.
- R3: Control bits 7:6 select the receive trigger level: 00 gives 1 byte, 01 gives 4, 10 gives 8 and 11 gives 14. With FIFOs enabled, `rda_irq` is high exactly when data is ready, `rx_irq_en` is 1 and the receive count is at least the trigger level.
- R4: An accepted control write whose bit 0 (FIFO enable) differs from the stored bit 0 empties both queues.
- R5: Control bit 1 empties only the receive queue and bit 2 empties only the transmit queue. The stored control value is the written value ANDed with 0xC9, so neither reset bit is ever kept.
- R6: A transmit write into a full queue stores the new byte and discards the oldest byte. The count stays at capacity, and `tx_overflow` is high during that write cycle.
- R7: While the receive queue is full, `rx_ready` is low. An offered byte is dropped, the count is unchanged and `lsr_oe` sets. A pulse on `lsr_rd` with no new drop clears `lsr_oe`.
- R8: A receive-buffer read presents the oldest byte on `rbr_rdata` in the read cycle and pops it. Data-ready falls when the queue empties. Reading an empty queue returns 0x00.
- R9: A transmit write clears holding-empty and transmitter-empty. Holding-empty returns when the transmit queue is empty. Transmitter-empty returns one cycle after the queue is empty while `tx_line_idle` is high.
- R10: Control writes have no effect while `cfg_fifo_mode_en` is 0. A write equal to the stored value has no effect.
- R11: With FIFOs disabled, each queue holds one byte. A second receive byte is dropped with overrun, a second transmit write replaces the held byte, and `rda_irq` follows data-ready and `rx_irq_en` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fifo_mode_en | input | 1 | Allows control-register writes (FIFO-capable build) |
| rx_irq_en | input | 1 | Receive data interrupt enable |
| fcr_wr | input | 1 | Control-register write strobe |
| fcr_wdata | input | 8 | Control-register write value |
| thr_wr | input | 1 | Transmit holding write strobe |
| thr_wdata | input | 8 | Byte to transmit |
| rbr_rd | input | 1 | Receive buffer read strobe |
| rbr_rdata | output | 8 | Oldest received byte, 0x00 when empty |
| lsr_rd | input | 1 | Status read strobe, clears overrun |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | A byte waits to be sent |
| tx_ready | input | 1 | Line side takes the byte |
| tx_data | output | 8 | Oldest transmit byte |
| tx_line_idle | input | 1 | Line-side shifter is idle |
| fcr_q | output | 8 | Stored control value |
| rx_count | output | 5 | Bytes in receive queue |
| tx_count | output | 5 | Bytes in transmit queue |
| lsr_dr | output | 1 | Data ready |
| lsr_thre | output | 1 | Transmit holding empty |
| lsr_temt | output | 1 | Transmitter empty |
| lsr_oe | output | 1 | Receive overrun |
| tx_overflow | output | 1 | Current transmit write lands on a full queue |
| rda_irq | output | 1 | Received-data-available interrupt |

## Verification
The bench sweeps every trigger code against every fill level from 1 to 16. A wrong level decode or an off-by-one comparison would move the interrupt edge by one byte. It fills the transmit queue and then writes past capacity. A design that refused the write, or that failed to advance the read side, would deliver the stale bytes instead of the two newest. It also checks that each reset bit empties its own queue while the other queue's count is untouched, and that toggling the enable bit empties both. Finally, it confirms that writes while disabled, and writes equal to the stored value, leave held data in place; a design that flushed on every write would lose bytes there.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned Q_DEPTH     = 16;
  localparam logic [7:0]  CTRL_KEEP   = 8'hC9;

  typedef enum logic [1:0] {
    LVL_ONE     = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_NEAR    = 2'b11
  } lvl_sel_e;
endpackage

// File: rtl/sfc_byte_fifo.sv
module sfc_byte_fifo #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned W         = 8,
  parameter bit          OVERWRITE = 1'b0,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          lost
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          nonempty, do_pop, wr_en, drop_old;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty = (count != '0);
  assign full     = single ? nonempty : (count == CW'(DEPTH));
  assign do_pop   = pop && nonempty;
  assign lost     = push && full;

  generate
    if (OVERWRITE) begin : g_ovw
      assign wr_en    = push;
      assign drop_old = push && full && !do_pop;
    end else begin : g_drop
      assign wr_en    = push && !full;
      assign drop_old = 1'b0;
    end
  endgenerate

  assign dout = nonempty ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (wr_en && !clr) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= nxt(wptr);
      if (do_pop || drop_old) rptr <= nxt(rptr);
      count <= count + CW'(wr_en && !drop_old) - CW'(do_pop);
    end
  end

  p_count_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_full_push_holds_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (count == $past(count)));

  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));
endmodule

// File: rtl/sfc_fcr_ctrl.sv
module sfc_fcr_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic          wr,
  input  logic [7:0]    wdata,
  output logic [7:0]    fcr_q,
  output logic          fifo_en,
  output logic [CW-1:0] trig,
  output logic          flush_rx,
  output logic          flush_tx
);
  logic take, toggle;

  function automatic logic [CW-1:0] level_of(input lvl_sel_e s);
    case (s)
      LVL_ONE:     return CW'(1);
      LVL_QUARTER: return CW'(DEPTH / 4);
      LVL_HALF:    return CW'(DEPTH / 2);
      default:     return CW'(DEPTH - 2);
    endcase
  endfunction

  assign take     = cfg_en && wr && (wdata != fcr_q);
  assign toggle   = take && (wdata[0] != fcr_q[0]);
  assign flush_rx = toggle || (take && wdata[1]);
  assign flush_tx = toggle || (take && wdata[2]);
  assign fifo_en  = fcr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_q <= 8'h00;
      trig  <= CW'(1);
    end else if (take) begin
      fcr_q <= wdata & CTRL_KEEP;
      if (wdata[0]) trig <= level_of(lvl_sel_e'(wdata[7:6]));
    end
  end

  p_locked_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(fcr_q));

  p_trig_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig >= CW'(1)) && (trig <= CW'(DEPTH - 2)));
endmodule

// File: rtl/sfc_line_status.sv
module sfc_line_status #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          irq_en,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] trig,
  input  logic          thr_wr,
  input  logic          tx_pop,
  input  logic          tx_line_idle,
  input  logic          rx_drop,
  input  logic          lsr_rd,
  output logic          dr,
  output logic          thre,
  output logic          temt,
  output logic          oe,
  output logic          irq
);
  assign dr   = (rx_count != '0);
  assign thre = (tx_count == '0);
  assign irq  = dr && irq_en && (!fifo_en || (rx_count >= trig));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temt <= 1'b1;
      oe   <= 1'b0;
    end else begin
      if (thr_wr || tx_pop)               temt <= 1'b0;
      else if (thre && tx_line_idle)      temt <= 1'b1;
      if (rx_drop)                        oe   <= 1'b1;
      else if (lsr_rd)                    oe   <= 1'b0;
    end
  end

  p_write_clears_temt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !temt);

  p_drop_sets_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |=> oe);
endmodule

// File: rtl/serial_fifo_ctl.sv
module serial_fifo_ctl
  import sfc_pkg::*;
#(
  parameter int unsigned DEPTH = Q_DEPTH,
  parameter int unsigned W     = BYTE_W,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fifo_mode_en,
  input  logic          rx_irq_en,
  input  logic          fcr_wr,
  input  logic [7:0]    fcr_wdata,
  input  logic          thr_wr,
  input  logic [W-1:0]  thr_wdata,
  input  logic          rbr_rd,
  output logic [W-1:0]  rbr_rdata,
  input  logic          lsr_rd,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [W-1:0]  rx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [W-1:0]  tx_data,
  input  logic          tx_line_idle,
  output logic [7:0]    fcr_q,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          lsr_dr,
  output logic          lsr_thre,
  output logic          lsr_temt,
  output logic          lsr_oe,
  output logic          tx_overflow,
  output logic          rda_irq
);
  logic          fifo_en, flush_rx, flush_tx;
  logic [CW-1:0] trig;
  logic          rx_full, rx_lost, tx_full, tx_pop;

  sfc_fcr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_fifo_mode_en),
    .wr(fcr_wr), .wdata(fcr_wdata), .fcr_q(fcr_q), .fifo_en(fifo_en),
    .trig(trig), .flush_rx(flush_rx), .flush_tx(flush_tx)
  );

  sfc_byte_fifo #(.DEPTH(DEPTH), .W(W), .OVERWRITE(1'b0)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(flush_rx), .single(!fifo_en),
    .push(rx_valid), .din(rx_data), .pop(rbr_rd), .dout(rbr_rdata),
    .count(rx_count), .full(rx_full), .lost(rx_lost)
  );

  assign tx_pop = tx_valid && tx_ready;

  sfc_byte_fifo #(.DEPTH(DEPTH), .W(W), .OVERWRITE(1'b1)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(flush_tx), .single(!fifo_en),
    .push(thr_wr), .din(thr_wdata), .pop(tx_pop), .dout(tx_data),
    .count(tx_count), .full(tx_full), .lost(tx_overflow)
  );

  assign rx_ready = !rx_full;
  assign tx_valid = (tx_count != '0);

  sfc_line_status #(.DEPTH(DEPTH)) u_stat (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .irq_en(rx_irq_en),
    .rx_count(rx_count), .tx_count(tx_count), .trig(trig),
    .thr_wr(thr_wr), .tx_pop(tx_pop), .tx_line_idle(tx_line_idle),
    .rx_drop(rx_lost), .lsr_rd(lsr_rd), .dr(lsr_dr), .thre(lsr_thre),
    .temt(lsr_temt), .oe(lsr_oe), .irq(rda_irq)
  );

  p_toggle_flushes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fifo_mode_en && fcr_wr && (fcr_wdata[0] != fcr_q[0]))
      |=> (rx_count == '0 && tx_count == '0));
endmodule

// File: tb/sim_serial_fifo_ctl.sv
module sim_serial_fifo_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fifo_mode_en = 1'b0, rx_irq_en = 1'b0;
  logic fcr_wr = 1'b0, thr_wr = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic [7:0] fcr_wdata = '0, thr_wdata = '0, rx_data = '0;
  logic rx_valid = 1'b0, tx_ready = 1'b0, tx_line_idle = 1'b1;
  logic [7:0] rbr_rdata, tx_data, fcr_q;
  logic [4:0] rx_count, tx_count;
  logic rx_ready, tx_valid, lsr_dr, lsr_thre, lsr_temt, lsr_oe, tx_overflow, rda_irq;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  serial_fifo_ctl u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic fcr(input logic [7:0] v);
    fcr_wr = 1'b1; fcr_wdata = v; @(negedge clk); fcr_wr = 1'b0;
  endtask
  task automatic rxp(input logic [7:0] v);
    rx_valid = 1'b1; rx_data = v; @(negedge clk); rx_valid = 1'b0;
  endtask
  task automatic thw(input logic [7:0] v, output logic ovf);
    thr_wr = 1'b1; thr_wdata = v; ovf = tx_overflow; @(negedge clk); thr_wr = 1'b0;
  endtask
  task automatic rbr(output logic [7:0] v);
    rbr_rd = 1'b1; v = rbr_rdata; @(negedge clk); rbr_rd = 1'b0;
  endtask
  task automatic txp(output logic [7:0] v);
    tx_ready = 1'b1; v = tx_data; @(negedge clk); tx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rx_count", rx_count, 0); chk("R1 tx_count", tx_count, 0);
    chk("R1 dr", lsr_dr, 0); chk("R1 thre", lsr_thre, 1); chk("R1 temt", lsr_temt, 1);
    chk("R1 oe", lsr_oe, 0); chk("R1 fcr", fcr_q, 0); chk("R1 irq", rda_irq, 0);
    chk("R1 rx_ready", rx_ready, 1);

    // R10 writes locked when not configured
    fcr(8'h01); chk("R10 locked", fcr_q, 8'h00);
    cfg_fifo_mode_en = 1'b1;
    fcr(8'h01); chk("R2 enable", fcr_q, 8'h01);

    // R2 / R7 fill receive queue
    for (int i = 0; i < 16; i++) begin
      rxp(8'h30 + 8'(i));
      chk("R2 rx_count", rx_count, i + 1); chk("R2 dr", lsr_dr, 1);
    end
    chk("R7 rx_ready full", rx_ready, 0);
    rxp(8'hEE);
    chk("R7 count kept", rx_count, 16); chk("R7 oe set", lsr_oe, 1);
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;
    chk("R7 oe cleared", lsr_oe, 0);

    // R8 drain in order, empty read
    for (int i = 0; i < 16; i++) begin
      rbr(b);
      chk("R2 order", b, 8'h30 + i); chk("R8 rx_count", rx_count, 15 - i);
    end
    chk("R8 dr falls", lsr_dr, 0);
    rbr(b); chk("R8 empty read", b, 0); chk("R8 empty count", rx_count, 0);

    // R3 trigger sweep
    rx_irq_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      int lvl;
      lvl = (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
      fcr({2'(c), 6'b000011});
      chk("R5 stored mask", fcr_q, {2'(c), 6'b000001});
      chk("R5 rx flushed", rx_count, 0);
      for (int n = 1; n <= 16; n++) begin
        rxp(8'(n));
        chk("R3 irq vs level", rda_irq, (n >= lvl) ? 1 : 0);
      end
    end
    rx_irq_en = 1'b0;
    lsr_rd = 1'b1; @(negedge clk); lsr_rd = 1'b0;

    // R5 reset bits act on their own queue only
    fcr(8'hC3);
    chk("R5 rx clr", rx_count, 0);
    for (int i = 0; i < 3; i++) thw(8'(i), o);
    rxp(8'h01); rxp(8'h02);
    fcr(8'hC3);
    chk("R5 rx only", rx_count, 0); chk("R5 tx kept", tx_count, 3);
    rxp(8'h03); rxp(8'h04);
    fcr(8'hC5);
    chk("R5 tx only", tx_count, 0); chk("R5 rx kept", rx_count, 2);
    fcr(8'hFF);
    chk("R5 mask C9", fcr_q, 8'hC9); chk("R5 both", rx_count + tx_count, 0);
    fcr(8'h01);
    chk("R5 restore", fcr_q, 8'h01);

    // R9 status bits
    tx_line_idle = 1'b0;
    thw(8'h50, o);
    chk("R9 thre low", lsr_thre, 0); chk("R9 temt low", lsr_temt, 0);
    chk("R9 tx_valid", tx_valid, 1);
    txp(b); chk("R9 data", b, 8'h50);
    chk("R9 thre back", lsr_thre, 1); chk("R9 temt waits", lsr_temt, 0);
    tx_line_idle = 1'b1; @(negedge clk);
    chk("R9 temt back", lsr_temt, 1);

    // R6 overwrite of oldest
    for (int i = 0; i < 16; i++) begin
      thw(8'h60 + 8'(i), o); chk("R6 no ovf", o, 0);
    end
    thw(8'hA0, o); chk("R6 ovf flag", o, 1); chk("R6 count", tx_count, 16);
    thw(8'hA1, o); chk("R6 ovf flag2", o, 1); chk("R6 count2", tx_count, 16);
    for (int i = 0; i < 16; i++) begin
      int e;
      e = (i < 14) ? (8'h62 + i) : (i == 14 ? 8'hA0 : 8'hA1);
      txp(b); chk("R6 sequence", b, e);
    end
    chk("R6 drained thre", lsr_thre, 1);

    // R4 toggle flushes both
    rxp(8'h11); rxp(8'h12); rxp(8'h13);
    thw(8'h21, o); thw(8'h22, o);
    fcr(8'h00);
    chk("R4 rx", rx_count, 0); chk("R4 tx", tx_count, 0); chk("R4 fcr", fcr_q, 0);

    // R11 single-byte mode
    rx_irq_en = 1'b1;
    rxp(8'h77);
    chk("R11 count", rx_count, 1); chk("R11 ready", rx_ready, 0); chk("R11 irq", rda_irq, 1);
    rxp(8'h78);
    chk("R11 oe", lsr_oe, 1);
    // R10 equal write and locked write leave data
    fcr(8'h00); chk("R10 equal write", rx_count, 1);
    cfg_fifo_mode_en = 1'b0;
    fcr(8'h01); chk("R10 locked data", rx_count, 1); chk("R10 locked fcr", fcr_q, 0);
    rbr(b); chk("R11 held byte", b, 8'h77);
    thw(8'h11, o); chk("R11 first tx", o, 0);
    thw(8'h22, o); chk("R11 replace flag", o, 1); chk("R11 tx count", tx_count, 1);
    txp(b); chk("R11 replaced", b, 8'h22);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule